// File: doc/BRIEF.md
# Quadrature Position Counter with Event Interrupts

This block turns the two phase signals of an incremental encoder into a signed position count. It can count every phase edge, or one edge per full cycle. It also watches four event sources: a latch input, a count-stop input, a Z pulse gated by an origin input, and a match between the count and a programmable comparator. Each source sets its own sticky pending bit. One interrupt line is the OR of every pending bit whose enable is set.

Software uses a small synchronous write / combinational read bus with six word addresses. Address 0 is control, 1 is mode, 2 is status, 3 is the comparator, 4 is the live count and 5 is the latched count.

All external inputs pass through two-flop synchronizers. Phase and event inputs are sampled on a timebase tick. That tick comes from a shared backplane clock-enable while edges of that signal keep arriving. When they stop arriving, the tick comes from an internal divider. An output reports which of the two sources is in use.

Top module: `quadPosCounter`

## Requirements
- R1: With control bit 12 set, every single-phase change of {A,B} moves the count by one. Forward order 00,10,11,01 (A leads B) counts up, the reverse order counts down, and the count wraps modulo 2^16.
- R2: With control bit 12 clear, the count changes only on a rising edge of A. It counts up when B is low at that edge and down when B is high.
- R3: After reset the count, the latched count and the comparator read zero. The interrupt and the clock-ok output are low. Within one cycle the comparator pending bit (status bit 12) and the live equal flag (status bit 4) are set, because the count equals the comparator.
- R4: Status bit 4 reads 1 while the count equals the comparator (address 3). Status bit 12 is set in every cycle that holds. With control bit 11 set, the interrupt rises, including straight after reset.
- R5: A pending bit (latch 13, stop 14, origin 15, comparator 12) clears only on a status write with that bit at zero. A one written there leaves it unchanged, and a new event in the same cycle wins over the clear.
- R6: Mode bit 14 picks the latch edge: 0 for rising, 1 for falling. The picked edge copies the count into address 5 and sets status bit 13. The other edge does neither.
- R7: A rising edge on the stop input sets status bit 14 and the inhibit flag (mode bit 9). While inhibit is set the count holds, and writing mode bit 9 back to zero lets counting resume.
- R8: When Z and origin become high together while mode bit 10 is zero, the count is cleared to zero and status bit 15 is set. With mode bit 10 set, or with only one of the two inputs high, neither happens.
- R9: The interrupt is high exactly when some pending bit has its enable set. The enables are control bit 8 (latch), 9 (stop), 10 (origin) and 11 (comparator). Pending bits stay readable while masked.
- R10: Clock-ok rises once backplane clock-enable edges arrive and then times the counter from them. It falls after LOSS_LIMIT cycles with no edge, and counting then continues from the internal divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| bpClkEn | input | 1 | Shared backplane clock-enable, asynchronous |
| phaseA | input | 1 | Encoder phase A |
| phaseB | input | 1 | Encoder phase B |
| zPulse | input | 1 | Encoder index pulse |
| originIn | input | 1 | Origin / clear request |
| latchIn | input | 1 | External latch request |
| stopIn | input | 1 | External count-stop request |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| irq | output | 1 | Combined interrupt request |
| clkOk | output | 1 | High while the backplane timebase is in use |

## Verification
A wrong phase decode or a wrong inhibit state shows up within one tick of the next phase change, as a count that is off by one, has the wrong sign, or does not move. The bench reads the count after each step to catch this. A pending bit that is lost, or set by mistake, changes irq and the status word in the cycle after the event or the clearing write, so both are read right after every event. A stuck timebase selector shows on clkOk only after the loss window, which is why the bench also checks that counting goes on once the backplane edges stop.

// File: rtl/qpcPkg.sv
package qpcPkg;

  localparam int BUS_W = 16;
  localparam int ADDR_W = 3;
  localparam int NUM_EV = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 3'd0,
    ADR_MODE = 3'd1,
    ADR_STAT = 3'd2,
    ADR_CMP  = 3'd3,
    ADR_CNT  = 3'd4,
    ADR_LAT  = 3'd5
  } qpcAddr_e;

  // control word
  localparam int CTRL_EN_LSB = 8;
  localparam int CTRL_X4     = 12;
  // mode word
  localparam int MODE_INHIBIT = 9;
  localparam int MODE_ORGHOLD = 10;
  localparam int MODE_LATFALL = 14;
  // status word
  localparam int STAT_EQ = 4;

  // event index: 0 latch, 1 stop, 2 origin, 3 comparator
  function automatic int statBit(input int idx);
    return (idx == 3) ? 12 : 13 + idx;
  endfunction

  typedef struct packed {
    logic stepEn;
    logic stepUp;
    logic zeroCnt;
    logic capture;
  } qpcStrobe_t;

endpackage

// File: rtl/qpcSync.sv
module qpcSync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) chain[0] <= '0;
        else       chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/qpcCtrl.sv
module qpcCtrl
  import qpcPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int INT_DIV = 4,
  parameter int LOSS_LIMIT = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bpClkEn,
  input  logic                phaseA,
  input  logic                phaseB,
  input  logic                zPulse,
  input  logic                originIn,
  input  logic                latchIn,
  input  logic                stopIn,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [BUS_W-1:0]    busRdata,
  input  logic [CNT_W-1:0]    countQ,
  input  logic [CNT_W-1:0]    latchQ,
  input  logic                cmpEq,
  output logic [CNT_W-1:0]    cmpQ,
  output qpcStrobe_t          strobe,
  output logic [NUM_EV-1:0]   enables,
  output logic [NUM_EV-1:0]   pending,
  output logic                inhibit,
  output logic                irq,
  output logic                clkOk
);

  localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam int GAP_W = $clog2(LOSS_LIMIT + 1);
  localparam int NIN = 7;

  // synchronized inputs
  logic [NIN-1:0] syncQ;
  qpcSync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .d({bpClkEn, stopIn, latchIn, originIn, zPulse, phaseB, phaseA}),
    .q(syncQ)
  );
  logic sA, sB, sZ, sOrg, sLat, sStop, sBp;
  assign {sBp, sStop, sLat, sOrg, sZ, sB, sA} = syncQ;

  // timebase selection
  logic bpPrev, bpEdge, tick, intTick;
  logic [DIV_W-1:0] divCnt;
  logic [GAP_W-1:0] gapCnt;

  assign bpEdge  = sBp & ~bpPrev;
  assign intTick = (divCnt == DIV_W'(INT_DIV - 1));
  assign tick    = clkOk ? bpEdge : intTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bpPrev <= 1'b0;
      divCnt <= '0;
      gapCnt <= '0;
      clkOk  <= 1'b0;
    end else begin
      bpPrev <= sBp;
      divCnt <= intTick ? '0 : divCnt + 1'b1;
      if (bpEdge) begin
        gapCnt <= '0;
        clkOk  <= 1'b1;
      end else if (gapCnt == GAP_W'(LOSS_LIMIT)) begin
        clkOk  <= 1'b0;
      end else begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  // tick-sampled history
  logic pA, pB, pLat, pStop, pOrgCond;
  logic orgCond;
  assign orgCond = sZ & sOrg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {pA, pB, pLat, pStop, pOrgCond} <= '0;
    end else if (tick) begin
      pA <= sA;
      pB <= sB;
      pLat <= sLat;
      pStop <= sStop;
      pOrgCond <= orgCond;
    end
  end

  // software registers
  logic x4Mode, latchFall, originHold;
  logic wrCtrl, wrMode, wrStat, wrCmp;
  assign wrCtrl = busWr && (busAddr == ADR_CTRL);
  assign wrMode = busWr && (busAddr == ADR_MODE);
  assign wrStat = busWr && (busAddr == ADR_STAT);
  assign wrCmp  = busWr && (busAddr == ADR_CMP);

  // events
  logic latchEv, stopEv, originEv;
  assign latchEv  = tick & (latchFall ? (pLat & ~sLat) : (~pLat & sLat));
  assign stopEv   = tick & sStop & ~pStop;
  assign originEv = tick & orgCond & ~pOrgCond & ~originHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enables    <= '0;
      x4Mode     <= 1'b0;
      latchFall  <= 1'b0;
      originHold <= 1'b0;
      inhibit    <= 1'b0;
      cmpQ       <= '0;
    end else begin
      if (wrCtrl) begin
        enables <= busWdata[CTRL_EN_LSB +: NUM_EV];
        x4Mode  <= busWdata[CTRL_X4];
      end
      if (wrMode) begin
        inhibit    <= busWdata[MODE_INHIBIT];
        originHold <= busWdata[MODE_ORGHOLD];
        latchFall  <= busWdata[MODE_LATFALL];
      end
      if (stopEv) inhibit <= 1'b1;
      if (wrCmp) cmpQ <= busWdata[CNT_W-1:0];
    end
  end

  // sticky pending bits
  logic [NUM_EV-1:0] setEv;
  assign setEv = {cmpEq, originEv, stopEv, latchEv};

  for (genvar i = 0; i < NUM_EV; i++) begin : g_pend
    localparam int SB = statBit(i);
    always_ff @(posedge clk) begin
      if (!rstN) pending[i] <= 1'b0;
      else       pending[i] <= setEv[i] | (pending[i] & ~(wrStat & ~busWdata[SB]));
    end
  end

  assign irq = |(pending & enables);

  // quadrature decode
  logic aChg, bChg, rawStep, rawUp;
  assign aChg = sA ^ pA;
  assign bChg = sB ^ pB;

  always_comb begin
    if (x4Mode) begin
      rawStep = aChg ^ bChg;
      rawUp   = sA ^ pB;
    end else begin
      rawStep = aChg & ~bChg & sA;
      rawUp   = ~sB;
    end
  end

  always_comb begin
    strobe.zeroCnt = originEv;
    strobe.capture = latchEv;
    strobe.stepUp  = rawUp;
    strobe.stepEn  = tick & rawStep & ~inhibit & ~originEv;
  end

  // read-back
  logic [BUS_W-1:0] cntExt, latExt, cmpExt, statWord;
  always_comb begin
    cntExt = '0;
    latExt = '0;
    cmpExt = '0;
    cntExt[CNT_W-1:0] = countQ;
    latExt[CNT_W-1:0] = latchQ;
    cmpExt[CNT_W-1:0] = cmpQ;
    statWord = '0;
    statWord[STAT_EQ] = cmpEq;
    for (int i = 0; i < NUM_EV; i++) statWord[statBit(i)] = pending[i];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADR_CTRL: begin
        busRdata[CTRL_EN_LSB +: NUM_EV] = enables;
        busRdata[CTRL_X4] = x4Mode;
      end
      ADR_MODE: begin
        busRdata[MODE_INHIBIT] = inhibit;
        busRdata[MODE_ORGHOLD] = originHold;
        busRdata[MODE_LATFALL] = latchFall;
      end
      ADR_STAT: busRdata = statWord;
      ADR_CMP:  busRdata = cmpExt;
      ADR_CNT:  busRdata = cntExt;
      ADR_LAT:  busRdata = latExt;
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/qpcData.sv
module qpcData
  import qpcPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qpcStrobe_t       strobe,
  input  logic [CNT_W-1:0] cmpQ,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] latchQ,
  output logic             cmpEq
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.zeroCnt) begin
      countQ <= '0;
    end else if (strobe.stepEn) begin
      countQ <= strobe.stepUp ? countQ + 1'b1 : countQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              latchQ <= '0;
    else if (strobe.capture) latchQ <= countQ;
  end

  assign cmpEq = (countQ == cmpQ);

endmodule

// File: rtl/quadPosCounter.sv
module quadPosCounter
  import qpcPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int INT_DIV = 4,
  parameter int LOSS_LIMIT = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bpClkEn,
  input  logic              phaseA,
  input  logic              phaseB,
  input  logic              zPulse,
  input  logic              originIn,
  input  logic              latchIn,
  input  logic              stopIn,
  input  logic              busWr,
  input  logic [2:0]        busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              irq,
  output logic              clkOk
);

  logic [CNT_W-1:0]  countQ, latchQ, cmpQ;
  logic              cmpEq, inhibit;
  logic [NUM_EV-1:0] enables, pending;
  qpcStrobe_t        strobe;

  qpcCtrl #(
    .CNT_W(CNT_W), .INT_DIV(INT_DIV),
    .LOSS_LIMIT(LOSS_LIMIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bpClkEn(bpClkEn),
    .phaseA(phaseA), .phaseB(phaseB), .zPulse(zPulse),
    .originIn(originIn), .latchIn(latchIn), .stopIn(stopIn),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .countQ(countQ), .latchQ(latchQ), .cmpEq(cmpEq), .cmpQ(cmpQ),
    .strobe(strobe), .enables(enables), .pending(pending), .inhibit(inhibit),
    .irq(irq), .clkOk(clkOk)
  );

  qpcData #(.CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpQ(cmpQ),
    .countQ(countQ), .latchQ(latchQ), .cmpEq(cmpEq)
  );

endmodule

// File: rtl/qpcChecker.sv
module qpcChecker
  import qpcPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  countQ,
  input logic [CNT_W-1:0]  latchQ,
  input logic [CNT_W-1:0]  cmpQ,
  input qpcStrobe_t        strobe,
  input logic [NUM_EV-1:0] enables,
  input logic [NUM_EV-1:0] pending,
  input logic              inhibit,
  input logic              irq,
  input logic              busWr,
  input logic [2:0]        busAddr,
  input logic [15:0]       busWdata
);

  assert_inhibit_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inhibit && !strobe.zeroCnt) |=> $stable(countQ));

  assert_cmp_pend_R4: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == cmpQ) |=> pending[3]);

  assert_latch_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pending[0] && !(busWr && busAddr == 3'd2 && !busWdata[13])) |=> pending[0]);

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|enables));

  assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (latchQ == $past(countQ)));

  assert_origin_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroCnt |=> (countQ == '0));

endmodule

bind quadPosCounter qpcChecker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .countQ(countQ), .latchQ(latchQ), .cmpQ(cmpQ),
  .strobe(strobe), .enables(enables), .pending(pending), .inhibit(inhibit),
  .irq(irq), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata)
);

// File: tb/sim_quadPosCounter.sv
module sim_quadPosCounter;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;
  localparam int LOSS = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bpClkEn = 1'b0, phaseA = 1'b0, phaseB = 1'b0, zPulse = 1'b0;
  logic originIn = 1'b0, latchIn = 1'b0, stopIn = 1'b0;
  logic busWr = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic irq, clkOk;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  bit bpRun = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quadPosCounter u0 (
    .clk(clk), .rstN(rstN), .bpClkEn(bpClkEn), .phaseA(phaseA), .phaseB(phaseB),
    .zPulse(zPulse), .originIn(originIn), .latchIn(latchIn), .stopIn(stopIn),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .clkOk(clkOk)
  );

  typedef struct packed {
    logic       x4;
    logic       up;
    logic [7:0] n;
    logic [15:0] exp;
  } vec_t;

  // cumulative count after each row; R1 rows use x4, R2 rows use x1
  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b1, 8'd5, 16'd5},
    '{1'b1, 1'b0, 8'd3, 16'd2},
    '{1'b0, 1'b1, 8'd8, 16'd4},
    '{1'b0, 1'b0, 8'd4, 16'd3},
    '{1'b1, 1'b0, 8'd6, 16'hFFFD},
    '{1'b1, 1'b1, 8'd4, 16'd1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stepQ(input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      ph = up ? (ph + 1) % 4 : (ph + 3) % 4;
      case (ph)
        0: {phaseA, phaseB} = 2'b00;
        1: {phaseA, phaseB} = 2'b10;
        2: {phaseA, phaseB} = 2'b11;
        default: {phaseA, phaseB} = 2'b01;
      endcase
      waitc(HOLD);
    end
  endtask

  initial begin : bpDrive
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      bpClkEn = bpRun && ((cnt % 6) < 3);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    waitc(4);
    rstN = 1'b1;
    waitc(2);

    // R3 reset state
    rd(3'd4, v); chk("R3 count", v, 16'd0);
    rd(3'd5, v); chk("R3 latch", v, 16'd0);
    chk("R3 irq", {15'd0, irq}, 16'd0);
    chk("R3 clkOk", {15'd0, clkOk}, 16'd0);
    rd(3'd2, v); chk("R3 status eq+pend", v, 16'h1010);

    // R4 comparator match from zero state fires once enabled
    wr(3'd0, 16'h0800); waitc(2);
    chk("R4 irq from reset", {15'd0, irq}, 16'd1);

    // R5 clear after moving the comparator away
    wr(3'd3, 16'd100);
    wr(3'd2, 16'h0000); waitc(2);
    chk("R5 irq cleared", {15'd0, irq}, 16'd0);
    rd(3'd2, v); chk("R5 status cleared", v, 16'h0000);

    // R1 / R2 table
    for (int k = 0; k < 6; k++) begin
      wr(3'd0, 16'h0800 | (VEC[k].x4 ? 16'h1000 : 16'h0000));
      stepQ(VEC[k].up, int'(VEC[k].n));
      rd(3'd4, v);
      chk(VEC[k].x4 ? "R1 x4 count" : "R2 x1 count", v, VEC[k].exp);
    end

    // R4 comparator match during counting (count 1 -> 3)
    wr(3'd0, 16'h1800);
    wr(3'd3, 16'd3);
    stepQ(1'b1, 2);
    rd(3'd2, v); chk("R4 status match", v & 16'h1010, 16'h1010);
    chk("R4 irq match", {15'd0, irq}, 16'd1);
    stepQ(1'b1, 1);
    wr(3'd2, 16'hEFFF); waitc(2);
    chk("R5 single clear irq", {15'd0, irq}, 16'd0);
    rd(3'd2, v); chk("R5 single clear bit", v & 16'h1010, 16'h0000);

    // R6 latch, rising edge select
    wr(3'd0, 16'h1900);
    latchIn = 1'b1; waitc(HOLD);
    rd(3'd5, v); chk("R6 latched value", v, 16'd4);
    rd(3'd2, v); chk("R6 latch pend", v & 16'h2000, 16'h2000);
    chk("R6 irq", {15'd0, irq}, 16'd1);
    wr(3'd2, 16'hFFFF); waitc(2);
    rd(3'd2, v); chk("R5 write one keeps", v & 16'h2000, 16'h2000);
    wr(3'd2, 16'hDFFF); waitc(2);
    rd(3'd2, v); chk("R5 latch cleared", v & 16'h2000, 16'h0000);
    stepQ(1'b1, 2);
    rd(3'd5, v); chk("R6 latch holds", v, 16'd4);
    latchIn = 1'b0; waitc(HOLD);
    rd(3'd2, v); chk("R6 falling ignored", v & 16'h2000, 16'h0000);
    wr(3'd1, 16'h4000);
    rd(3'd1, v); chk("R6 mode readback", v, 16'h4000);
    latchIn = 1'b1; waitc(HOLD);
    rd(3'd2, v); chk("R6 rising ignored", v & 16'h2000, 16'h0000);
    latchIn = 1'b0; waitc(HOLD);
    rd(3'd2, v); chk("R6 falling event", v & 16'h2000, 16'h2000);
    rd(3'd5, v); chk("R6 falling capture", v, 16'd6);
    wr(3'd2, 16'hDFFF);

    // R7 count stop
    wr(3'd0, 16'h1A00);
    stopIn = 1'b1; waitc(HOLD);
    rd(3'd2, v); chk("R7 stop pend", v & 16'h4000, 16'h4000);
    rd(3'd1, v); chk("R7 inhibit set", v, 16'h4200);
    chk("R7 irq", {15'd0, irq}, 16'd1);
    stepQ(1'b1, 3);
    rd(3'd4, v); chk("R7 count held", v, 16'd6);
    stopIn = 1'b0;
    wr(3'd2, 16'hBFFF);
    wr(3'd1, 16'h4000); waitc(2);
    chk("R7 irq cleared", {15'd0, irq}, 16'd0);
    stepQ(1'b1, 1);
    rd(3'd4, v); chk("R7 resumes", v, 16'd7);

    // R8 origin
    wr(3'd0, 16'h1C00);
    wr(3'd1, 16'h4400);
    zPulse = 1'b1; originIn = 1'b1; waitc(HOLD);
    rd(3'd4, v); chk("R8 hold blocks clear", v, 16'd7);
    rd(3'd2, v); chk("R8 hold blocks pend", v & 16'h8000, 16'h0000);
    zPulse = 1'b0; originIn = 1'b0; waitc(HOLD);
    wr(3'd1, 16'h4000);
    zPulse = 1'b1; waitc(HOLD);
    rd(3'd4, v); chk("R8 Z alone", v, 16'd7);
    originIn = 1'b1; waitc(HOLD);
    rd(3'd4, v); chk("R8 count cleared", v, 16'd0);
    rd(3'd2, v); chk("R8 origin pend", v & 16'h8000, 16'h8000);
    chk("R8 irq", {15'd0, irq}, 16'd1);

    // R9 masking keeps pending visible
    wr(3'd0, 16'h1000); waitc(2);
    chk("R9 masked irq", {15'd0, irq}, 16'd0);
    rd(3'd2, v); chk("R9 pend still set", v & 16'h8000, 16'h8000);
    zPulse = 1'b0; originIn = 1'b0; waitc(HOLD);

    // R10 backplane timebase
    bpRun = 1'b1; waitc(40);
    chk("R10 clkOk high", {15'd0, clkOk}, 16'd1);
    stepQ(1'b1, 2);
    rd(3'd4, v); chk("R10 count on backplane", v, 16'd2);
    bpRun = 1'b0; waitc(LOSS + 20);
    chk("R10 clkOk low", {15'd0, clkOk}, 16'd0);
    stepQ(1'b1, 1);
    rd(3'd4, v); chk("R10 count on internal", v, 16'd3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule